// File: doc/BRIEF.md
# DMA Channel Interrupt Status Unit

This block collects the interrupt-worthy events of every channel of a DMA controller and turns them into one interrupt line. Each channel owns a raw status word. An event pulse from the channel engine is recorded in that word only where the channel's status-enable mask allows it. A second, independent signal-enable mask then selects which recorded bits may raise the interrupt. Software acknowledges events by writing ones to a per-channel clear register.

A summary register holds one bit per channel and shows which channels currently have a signalled bit pending. A global configuration register holds a controller-enable bit and a global interrupt-enable bit. Only the global interrupt-enable bit gates the output line. All registers sit behind a plain word-addressed write strobe and a combinational read port.

Status word layout (22 bits): bit 0 = one block finished, bit 1 = whole transfer finished, bits 5..14 and 16..21 = error causes. Bits 2..4, bit 15 and bits 22 and up are undefined.

Top module: `dma_irq_status`

## Requirements
- R1: After reset, every status, status-enable and signal-enable register and the global configuration register read 0, and `irq_o` is low.
- R2: A pulse on event bit b of channel c sets status bit b of c at the next rising edge only if status-enable bit b of c is 1. Otherwise the status bit stays 0.
- R3: A set status bit stays set, whatever the event inputs do, until software clears it.
- R4: Writing the clear register of channel c clears every status bit whose write-data bit is 1. Status bits whose write-data bit is 0 keep their value.
- R5: If an enabled event and a clear hit the same status bit in the same cycle, the bit is 1 afterwards.
- R6: Undefined bits (2..4, 15, 22 and up) of the status, status-enable and signal-enable registers always read 0. This holds even after writing all ones or pulsing every event.
- R7: `irq_o` is 1 exactly when global interrupt-enable (bit 1 of word 0) is 1 and some channel has a status bit that is 1 and whose signal-enable bit is 1. Controller enable (bit 0 of word 0) has no effect on `irq_o` and is output on `ctrl_en_o`.
- R8: Bit c of the summary register (word 1) is 1 exactly when channel c has a status bit set with its signal-enable bit set. It does not depend on global interrupt-enable.
- R9: The clear register reads 0. Writes to the summary register and to the status register change no state.
- R10: Address map in words: 0 global config, 1 summary. Channel c sits at 8+4c, with offset +0 status-enable, +1 signal-enable, +2 status (read-only), +3 clear (write-one-to-clear). Unmapped words read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_i | input | NCH*22 | Event pulses, channel c in bits [22c+21:22c] |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | AW | Word address |
| reg_wdata | input | DW | Write data |
| reg_rdata | output | DW | Read data for `reg_addr`, combinational |
| ctrl_en_o | output | 1 | Controller-enable bit of global config |
| irq_o | output | 1 | Interrupt line |

## Verification
Writes and events take effect at the rising edge they are presented at. Status, summary and `irq_o` therefore show the result one cycle after the stimulus, while a read reflects the register state of the current cycle with no delay. The bench drives every stimulus on the falling edge and updates its reference model just after the next rising edge. It compares the read data and `irq_o` on the following falling edge, so each result is checked in the first cycle it is due. Reads are issued with the strobe low and checked a moment after the address settles, never at an edge.

// File: rtl/dma_irq_status.sv
module dma_irq_status #(
  parameter int NCH = 4,
  parameter int AW  = 8,
  parameter int DW  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCH*22-1:0] ev_i,
  input  logic              reg_we,
  input  logic [AW-1:0]     reg_addr,
  input  logic [DW-1:0]     reg_wdata,
  output logic [DW-1:0]     reg_rdata,
  output logic              ctrl_en_o,
  output logic              irq_o
);
  localparam int SW = 22;
  localparam logic [SW-1:0] VALID = 22'h3F7FE3;
  localparam int A_CFG = 0;
  localparam int A_SUM = 1;
  localparam int CH_BASE = 8;

  logic [SW-1:0] st_q   [NCH];
  logic [SW-1:0] sten_q [NCH];
  logic [SW-1:0] sgen_q [NCH];
  logic [NCH-1:0] pend;
  logic [NCH*SW-1:0] st_flat, sten_flat;
  logic en_q, gie_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      gie_q <= 1'b0;
    end else if (reg_we && reg_addr == AW'(A_CFG)) begin
      en_q  <= reg_wdata[0];
      gie_q <= reg_wdata[1];
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    localparam int BA = CH_BASE + 4*c;
    logic w_sten, w_sgen, w_clr;
    logic [SW-1:0] clr_m;
    assign w_sten = reg_we && reg_addr == AW'(BA);
    assign w_sgen = reg_we && reg_addr == AW'(BA + 1);
    assign w_clr  = reg_we && reg_addr == AW'(BA + 3);
    assign clr_m  = w_clr ? reg_wdata[SW-1:0] : '0;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        st_q[c]   <= '0;
        sten_q[c] <= '0;
        sgen_q[c] <= '0;
      end else begin
        if (w_sten) sten_q[c] <= reg_wdata[SW-1:0] & VALID;
        if (w_sgen) sgen_q[c] <= reg_wdata[SW-1:0] & VALID;
        st_q[c] <= ((st_q[c] & ~clr_m) | (ev_i[c*SW +: SW] & sten_q[c])) & VALID;
      end
    end

    assign pend[c] = |(st_q[c] & sgen_q[c]);
    assign st_flat[c*SW +: SW]   = st_q[c];
    assign sten_flat[c*SW +: SW] = sten_q[c];
  end

  assign ctrl_en_o = en_q;
  assign irq_o     = gie_q & (|pend);

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == AW'(A_CFG)) reg_rdata[1:0] = {gie_q, en_q};
    if (reg_addr == AW'(A_SUM)) reg_rdata[NCH-1:0] = pend;
    for (int c = 0; c < NCH; c++) begin
      if (reg_addr == AW'(CH_BASE + 4*c))     reg_rdata[SW-1:0] = sten_q[c];
      if (reg_addr == AW'(CH_BASE + 4*c + 1)) reg_rdata[SW-1:0] = sgen_q[c];
      if (reg_addr == AW'(CH_BASE + 4*c + 2)) reg_rdata[SW-1:0] = st_q[c];
    end
  end
endmodule

module dma_irq_status_chk #(
  parameter int NCH = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NCH*22-1:0] ev_i,
  input logic [NCH*22-1:0] st_f,
  input logic [NCH*22-1:0] sten_f,
  input logic              gie,
  input logic              reg_we,
  input logic              irq_o
);
  localparam logic [21:0] VALID = 22'h3F7FE3;
  localparam logic [NCH*22-1:0] VALID_ALL = {NCH{VALID}};

  p_set_gated_r2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((st_f & ~$past(st_f) & ~$past(ev_i & sten_f)) == '0));

  p_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (|($past(st_f) & ~st_f)) |-> $past(reg_we));

  p_event_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(ev_i & sten_f) & ~st_f) == '0));

  p_undef_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_f & ~VALID_ALL) == '0) && ((sten_f & ~VALID_ALL) == '0));

  p_irq_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (gie && st_f != '0));
endmodule

bind dma_irq_status dma_irq_status_chk #(.NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .ev_i(ev_i), .st_f(st_flat), .sten_f(sten_flat),
  .gie(gie_q), .reg_we(reg_we), .irq_o(irq_o)
);

// File: tb/tb_dma_irq_status.sv
module tb_dma_irq_status;
  localparam int NCH = 4, AW = 8, DW = 32, SW = 22;
  localparam logic [SW-1:0] VALID = 22'h3F7FE3;

  logic clk = 0, rst_n = 0, reg_we = 0;
  logic [NCH*SW-1:0] ev_i = '0;
  logic [AW-1:0] reg_addr = '0;
  logic [DW-1:0] reg_wdata = '0, reg_rdata;
  logic ctrl_en_o, irq_o;
  int n_run = 0, n_fail = 0;

  logic [SW-1:0] m_st [NCH], m_sten [NCH], m_sgen [NCH];
  logic m_en = 0, m_gie = 0;

  dma_irq_status #(.NCH(NCH), .AW(AW), .DW(DW)) dut (.*);

  always #2 clk = ~clk;

  function automatic logic [NCH-1:0] exp_pend();
    logic [NCH-1:0] p;
    for (int c = 0; c < NCH; c++) p[c] = |(m_st[c] & m_sgen[c]);
    return p;
  endfunction

  task automatic chk(string req, logic [DW-1:0] got, logic [DW-1:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic rd(string req, int a, logic [DW-1:0] exp);
    reg_we = 0; reg_addr = AW'(a); #1;
    chk(req, reg_rdata, exp);
  endtask

  // one clock: present stimulus, update model after the edge, return at negedge
  task automatic cyc(logic [NCH*SW-1:0] ev, logic we, int a, logic [DW-1:0] wd);
    ev_i = ev; reg_we = we; reg_addr = AW'(a); reg_wdata = wd;
    @(posedge clk); #0.5;
    for (int c = 0; c < NCH; c++) begin
      logic [SW-1:0] clr;
      clr = (we && a == 8 + 4*c + 3) ? wd[SW-1:0] : '0;
      m_st[c] = ((m_st[c] & ~clr) | (ev[c*SW +: SW] & m_sten[c])) & VALID;
      if (we && a == 8 + 4*c)     m_sten[c] = wd[SW-1:0] & VALID;
      if (we && a == 8 + 4*c + 1) m_sgen[c] = wd[SW-1:0] & VALID;
    end
    if (we && a == 0) begin m_en = wd[0]; m_gie = wd[1]; end
    @(negedge clk);
    ev_i = '0; reg_we = 0;
  endtask

  task automatic chk_all(string req);
    chk(req, {31'b0, irq_o}, {31'b0, m_gie & (|exp_pend())});
    rd(req, 1, DW'(exp_pend()));
    for (int c = 0; c < NCH; c++) rd(req, 8 + 4*c + 2, DW'(m_st[c]));
  endtask

  initial begin
    #400000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int c = 0; c < NCH; c++) begin m_st[c] = 0; m_sten[c] = 0; m_sgen[c] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    chk("R1", {31'b0, irq_o}, 0);
    rd("R1", 0, 0);
    for (int c = 0; c < NCH; c++) begin
      rd("R1", 8 + 4*c, 0); rd("R1", 8 + 4*c + 1, 0); rd("R1", 8 + 4*c + 2, 0);
    end
    // R2 gating: events with enables 0, then enable bit 0 only on ch1
    cyc('1, 0, 0, 0);
    rd("R2", 8 + 2, 0);
    cyc('0, 1, 12, 32'h1);
    cyc('1, 0, 0, 0);
    rd("R2", 12 + 2, 32'h1);
    rd("R2", 8 + 2, 0);
    // R3 sticky
    repeat (3) cyc('0, 0, 0, 0);
    rd("R3", 14, 32'h1);
    // R7/R8 irq gating
    cyc('0, 1, 13, 32'h1);
    rd("R8", 1, 32'h2);
    chk("R7", {31'b0, irq_o}, 0);
    cyc('0, 1, 0, 32'h1);
    chk("R7", {31'b0, irq_o}, 0);
    chk("R7", {31'b0, ctrl_en_o}, 1);
    cyc('0, 1, 0, 32'h2);
    chk("R7", {31'b0, irq_o}, 1);
    // R6 undefined bits
    cyc('0, 1, 8, '1);
    rd("R6", 8, DW'(VALID));
    cyc('0, 1, 9, '1);
    rd("R6", 9, DW'(VALID));
    cyc('1, 0, 0, 0);
    rd("R6", 10, DW'(VALID));
    // R4 write zero then selective clear
    cyc('0, 1, 11, 32'h0);
    rd("R4", 10, DW'(VALID));
    cyc('0, 1, 11, 32'h3);
    rd("R4", 10, DW'(VALID & ~22'h3));
    // R5 event and clear in same cycle
    cyc({{(NCH-1)*SW{1'b0}}, 22'h20}, 1, 11, 32'h20);
    rd("R5", 10, DW'(VALID & ~22'h3));
    // R9 clear reads 0; writes to summary/status ignored
    rd("R9", 11, 0);
    cyc('0, 1, 1, 32'h0);
    cyc('0, 1, 10, 32'h0);
    rd("R9", 10, DW'(VALID & ~22'h3));
    rd("R9", 1, DW'(exp_pend()));
    // R10 unmapped
    rd("R10", 2, 0);
    rd("R10", 8 + 4*NCH, 0);
    // random mix
    for (int i = 0; i < 400; i++) begin
      logic [NCH*SW-1:0] ev;
      int c, a;
      for (int k = 0; k < NCH*SW; k++) ev[k] = ($urandom % 8) == 0;
      c = $urandom % NCH;
      case ($urandom % 6)
        0: a = 0;
        1: a = 8 + 4*c;
        2: a = 8 + 4*c + 1;
        default: a = 8 + 4*c + 3;
      endcase
      cyc(ev, ($urandom % 3) != 0, a, $urandom);
      chk_all("R2 R4 R5 R7 R8 random");
    end
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule